// File: doc/BRIEF.md
# Bit-Aligning Frame Delimiter Hunter with Trailing Checksum Verifier

This block sits behind a line decoder that delivers one recovered bit per enabled cycle, in the order the bits came off the wire. While a frame is arriving, it watches the bits for the start delimiter `10101011` at bit granularity. It does not assume that the delimiter lines up with any byte boundary. Everything up to and including the delimiter is dropped. From the next bit on, the stream is cut into bytes that are aligned to the delimiter, and each byte is presented as soon as its eighth bit is in.

The bytes also flow through a four-byte delay line. A byte enters the CRC-32 engine only once four newer bytes stand behind it, so the engine never sees the trailing checksum. When the decoder pulses the end-of-frame input, the block compares the four bytes still in the delay line with the inverted CRC register. It then reports three results: a pass/fail verdict, the number of aligned bytes, and whether leftover bits that did not fill a byte were discarded. Storage of the bytes and any parsing of their contents belong to the consumer.

Top module: `frame_align_fcs`

## Requirements
- R1: While hunting, the block keeps an 8-bit window of the most recent enabled bits, oldest bit first. It locks when the window equals `10101011`, whatever the alignment of that pattern to earlier bits. No byte is emitted for the preamble or for the delimiter.
- R2: The first bit after the delimiter becomes the most significant bit of aligned byte 0, and each later bit fills the next lower position. `byte_valid` is high for exactly the one cycle after the clock edge that samples the eighth bit of a byte.
- R3: Once the block has locked, later occurrences of `10101011` in the stream are treated as ordinary data.
- R4: `byte_index` counts the aligned bytes of a frame from 0. Two bytes are never presented on consecutive cycles.
- R5: The checksum uses the reflected polynomial 0xEDB88320 and starts from all ones. Bits are processed in received order, i.e. from bit 7 down to bit 0 of each aligned byte. Every aligned byte except the last four is included. The result is inverted before comparison. The j-th received bit of the trailing 32 must equal bit j of the inverted result.
- R6: `frame_good` is 1 only when the trailing four bytes match under R5. A single flipped bit anywhere after the delimiter yields 0.
- R7: A frame that ends without a delimiter reports `frame_good`=0 and `frame_len`=0, and emits no bytes.
- R8: A frame with fewer than four aligned bytes reports `frame_good`=0. A frame of exactly four bytes, all zero, is good.
- R9: Bits after the last complete byte are discarded and set `bits_dropped`=1. The verdict is still taken over the whole bytes. A frame that ends on a byte boundary reports `bits_dropped`=0.
- R10: If the edge that samples `frame_end` is edge E, `done` is high for the single cycle after edge E+1. `frame_good`, `frame_len` and `bits_dropped` change only together with `done` and are held until the next `done`.
- R11: Synchronous reset clears `byte_valid`, `done`, `frame_good`, `frame_len` and `bits_dropped` to 0 and returns to hunting, even in the middle of a frame.
- R12: Cycles with `bit_valid`=0 leave the alignment, the delimiter search and the checksum untouched, whatever is on `bit_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | `bit_in` carries a decoded bit this cycle |
| bit_in | input | 1 | Decoded line bit, in received order |
| frame_end | input | 1 | One-cycle pulse closing the current frame |
| byte_valid | output | 1 | Aligned byte present on `byte_data` |
| byte_data | output | 8 | Aligned byte, first received bit in bit 7 |
| byte_index | output | LEN_W | Position of `byte_data` within the frame |
| done | output | 1 | One-cycle pulse: frame results updated |
| frame_good | output | 1 | Trailing four bytes match the checksum |
| frame_len | output | LEN_W | Aligned byte count of the last frame |
| bits_dropped | output | 1 | Last frame ended with a partial byte |

## Verification
Two results are tied to exact cycles. An aligned byte appears one cycle after the edge that takes its eighth bit, and the frame verdict comes two edges after `frame_end` is sampled. The bench drives inputs on falling edges and reads outputs on falling edges. A monitor compares each `byte_valid` cycle against the expected byte for its index, and checks that the index matches the arrival order. The frame task checks that `done` is still low at the first falling edge after the `frame_end` edge and high at the second. It compares the verdict, length and drop flag only there.

// File: rtl/fa_pkg.sv
package fa_pkg;
  localparam int CRC_W     = 32;
  localparam int BYTE_W    = 8;
  localparam int FCS_BYTES = CRC_W / BYTE_W;

  localparam logic [CRC_W-1:0]  CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [CRC_W-1:0]  CRC_PRESET    = '1;
  localparam logic [BYTE_W-1:0] SFD_PATTERN   = 8'b10101011;

  typedef enum logic {HUNT = 1'b0, PASS = 1'b1} hunt_state_e;

  typedef logic [FCS_BYTES-1:0][BYTE_W-1:0] fcs_line_t;

  // Advance the reflected CRC by one aligned byte; bit 7 was received first.
  function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] c,
                                                input logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] r;
    logic             fb;
    r = c;
    for (int b = BYTE_W - 1; b >= 0; b--) begin
      fb = r[0] ^ d[b];
      r  = r >> 1;
      if (fb) r = r ^ CRC_POLY_REFL;
    end
    return r;
  endfunction

  // Gather the held bytes into a word whose bit j is the j-th received bit.
  function automatic logic [CRC_W-1:0] fcs_word(input fcs_line_t v);
    logic [CRC_W-1:0] w;
    for (int j = 0; j < CRC_W; j++)
      w[j] = v[FCS_BYTES - 1 - j / BYTE_W][BYTE_W - 1 - j % BYTE_W];
    return w;
  endfunction
endpackage

// File: rtl/fa_sfd_hunter.sv
module fa_sfd_hunter
  import fa_pkg::*;
#(
  parameter int               PAT_W   = 8,
  parameter logic [PAT_W-1:0] PATTERN = SFD_PATTERN
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_valid,
  input  logic bit_in,
  input  logic frame_end,
  output logic data_valid,
  output logic data_bit,
  output logic locked
);
  hunt_state_e      state;
  logic [PAT_W-1:0] window;
  logic [PAT_W-1:0] window_n;

  assign window_n   = {window[PAT_W-2:0], bit_in};
  assign locked     = (state == PASS);
  assign data_valid = bit_valid && locked;
  assign data_bit   = bit_in;

  always_ff @(posedge clk) begin
    if (rst || frame_end) begin
      state  <= HUNT;
      window <= '0;
    end else if (bit_valid && state == HUNT) begin
      window <= window_n;
      if (window_n == PATTERN) state <= PASS;
    end
  end
endmodule

// File: rtl/fa_bit_packer.sv
module fa_bit_packer
  import fa_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_bit,
  input  logic              flush,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data,
  output logic [LEN_W-1:0]  byte_index,
  output logic              end_pulse,
  output logic [LEN_W-1:0]  end_len,
  output logic              end_partial
);
  localparam int FILL_W = $clog2(BYTE_W);

  logic [BYTE_W-1:0] shreg;
  logic [FILL_W-1:0] fill;
  logic [FILL_W-1:0] fill_n;
  logic [LEN_W-1:0]  nbytes;
  logic [LEN_W-1:0]  nbytes_n;
  logic              emit;

  assign emit     = in_valid && (fill == FILL_W'(BYTE_W - 1));
  assign fill_n   = in_valid ? (emit ? '0 : fill + 1'b1) : fill;
  assign nbytes_n = emit ? nbytes + 1'b1 : nbytes;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg       <= '0;
      fill        <= '0;
      nbytes      <= '0;
      byte_valid  <= 1'b0;
      byte_data   <= '0;
      byte_index  <= '0;
      end_pulse   <= 1'b0;
      end_len     <= '0;
      end_partial <= 1'b0;
    end else begin
      byte_valid <= emit;
      end_pulse  <= flush;
      if (in_valid) shreg <= {shreg[BYTE_W-2:0], in_bit};
      if (emit) begin
        byte_data  <= {shreg[BYTE_W-2:0], in_bit};
        byte_index <= nbytes;
      end
      if (flush) begin
        fill        <= '0;
        nbytes      <= '0;
        end_len     <= nbytes_n;
        end_partial <= (fill_n != '0);
      end else begin
        fill   <= fill_n;
        nbytes <= nbytes_n;
      end
    end
  end
endmodule

// File: rtl/fa_fcs_check.sv
module fa_fcs_check
  import fa_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              end_pulse,
  input  logic [LEN_W-1:0]  end_len,
  input  logic              end_partial,
  input  logic              end_locked,
  output logic              done,
  output logic              frame_good,
  output logic [LEN_W-1:0]  frame_len,
  output logic              bits_dropped
);
  localparam int HELD_W = $clog2(FCS_BYTES + 1);

  fcs_line_t        line_q, line_n;
  logic [HELD_W-1:0] held_q, held_n;
  logic [CRC_W-1:0]  crc_q, crc_n;
  logic              full_n;
  logic              match_n;

  always_comb begin
    line_n = line_q;
    held_n = held_q;
    crc_n  = crc_q;
    if (in_valid) begin
      if (held_q == HELD_W'(FCS_BYTES)) crc_n = crc_byte(crc_q, line_q[FCS_BYTES-1]);
      line_n = {line_q[FCS_BYTES-2:0], in_data};
      if (held_q != HELD_W'(FCS_BYTES)) held_n = held_q + 1'b1;
    end
  end

  assign full_n  = (held_n == HELD_W'(FCS_BYTES));
  assign match_n = (fcs_word(line_n) == ~crc_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q       <= '0;
      held_q       <= '0;
      crc_q        <= CRC_PRESET;
      done         <= 1'b0;
      frame_good   <= 1'b0;
      frame_len    <= '0;
      bits_dropped <= 1'b0;
    end else if (end_pulse) begin
      done         <= 1'b1;
      frame_good   <= end_locked && full_n && match_n;
      frame_len    <= end_len;
      bits_dropped <= end_partial;
      line_q       <= '0;
      held_q       <= '0;
      crc_q        <= CRC_PRESET;
    end else begin
      done   <= 1'b0;
      line_q <= line_n;
      held_q <= held_n;
      crc_q  <= crc_n;
    end
  end
endmodule

// File: rtl/frame_align_fcs.sv
module frame_align_fcs
  import fa_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_valid,
  input  logic             bit_in,
  input  logic             frame_end,
  output logic             byte_valid,
  output logic [7:0]       byte_data,
  output logic [LEN_W-1:0] byte_index,
  output logic             done,
  output logic             frame_good,
  output logic [LEN_W-1:0] frame_len,
  output logic             bits_dropped
);
  logic             data_valid;
  logic             data_bit;
  logic             locked;
  logic             locked_at_end;
  logic             end_pulse;
  logic [LEN_W-1:0] end_len;
  logic             end_partial;

  fa_sfd_hunter #(.PAT_W(BYTE_W), .PATTERN(SFD_PATTERN)) u_hunt (
    .clk        (clk),
    .rst        (rst),
    .bit_valid  (bit_valid),
    .bit_in     (bit_in),
    .frame_end  (frame_end),
    .data_valid (data_valid),
    .data_bit   (data_bit),
    .locked     (locked)
  );

  always_ff @(posedge clk) begin
    if (rst)            locked_at_end <= 1'b0;
    else if (frame_end) locked_at_end <= locked;
  end

  fa_bit_packer #(.LEN_W(LEN_W)) u_pack (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (data_valid),
    .in_bit      (data_bit),
    .flush       (frame_end),
    .byte_valid  (byte_valid),
    .byte_data   (byte_data),
    .byte_index  (byte_index),
    .end_pulse   (end_pulse),
    .end_len     (end_len),
    .end_partial (end_partial)
  );

  fa_fcs_check #(.LEN_W(LEN_W)) u_fcs (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (byte_valid),
    .in_data      (byte_data),
    .end_pulse    (end_pulse),
    .end_len      (end_len),
    .end_partial  (end_partial),
    .end_locked   (locked_at_end),
    .done         (done),
    .frame_good   (frame_good),
    .frame_len    (frame_len),
    .bits_dropped (bits_dropped)
  );
endmodule

// File: rtl/fa_frame_chk.sv
module fa_frame_chk #(
  parameter int LEN_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             byte_valid,
  input logic             done,
  input logic             frame_good,
  input logic [LEN_W-1:0] frame_len,
  input logic             bits_dropped
);
  // R4
  byte_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    byte_valid |=> !byte_valid);

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(frame_good) && $stable(frame_len) && $stable(bits_dropped)));

  // R8
  short_frame_bad_chk: assert property (@(posedge clk) disable iff (rst)
    (done && frame_len < LEN_W'(4)) |-> !frame_good);

  // R10
  done_byte_excl_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !byte_valid);
endmodule

bind frame_align_fcs fa_frame_chk #(.LEN_W(LEN_W)) u_frame_chk (
  .clk          (clk),
  .rst          (rst),
  .byte_valid   (byte_valid),
  .done         (done),
  .frame_good   (frame_good),
  .frame_len    (frame_len),
  .bits_dropped (bits_dropped)
);

// File: tb/tb_frame_align_fcs.sv
module tb_frame_align_fcs;
  localparam int LEN_W = 12;

  typedef struct packed {
    logic [7:0] pre;
    logic [7:0] npay;
    logic [7:0] seed;
    logic [7:0] step;
    logic       gap;
    logic [2:0] tail;
    logic       flip;
    logic       good;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{8'd7,  8'd10, 8'h0C, 8'd29, 1'b0, 3'd0, 1'b0, 1'b1},
    '{8'd8,  8'd6,  8'h55, 8'd3,  1'b0, 3'd0, 1'b0, 1'b1},
    '{8'd13, 8'd0,  8'h00, 8'd0,  1'b0, 3'd0, 1'b0, 1'b1},
    '{8'd4,  8'd5,  8'hAB, 8'd0,  1'b0, 3'd0, 1'b0, 1'b1},
    '{8'd9,  8'd7,  8'h90, 8'd17, 1'b1, 3'd0, 1'b0, 1'b1},
    '{8'd6,  8'd8,  8'h01, 8'd1,  1'b0, 3'd3, 1'b0, 1'b1},
    '{8'd10, 8'd12, 8'h3C, 8'd77, 1'b0, 3'd0, 1'b1, 1'b0},
    '{8'd2,  8'd1,  8'hFF, 8'd0,  1'b0, 3'd7, 1'b0, 1'b1},
    '{8'd11, 8'd3,  8'h21, 8'd5,  1'b1, 3'd2, 1'b1, 1'b0}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             bit_valid = 1'b0;
  logic             bit_in = 1'b0;
  logic             frame_end = 1'b0;
  logic             byte_valid;
  logic [7:0]       byte_data;
  logic [LEN_W-1:0] byte_index;
  logic             done;
  logic             frame_good;
  logic [LEN_W-1:0] frame_len;
  logic             bits_dropped;

  always #2 clk = ~clk;

  frame_align_fcs #(.LEN_W(LEN_W)) dut (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
    .frame_end(frame_end), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_index(byte_index), .done(done), .frame_good(frame_good),
    .frame_len(frame_len), .bits_dropped(bits_dropped));

  int         checks = 0;
  int         errors = 0;
  logic       stim [0:2047];
  int         nbits;
  logic [7:0] exp_bytes [0:255];
  int         exp_n;
  logic       exp_drop;
  int         rx_count;
  logic       monitor_on = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Monitor: every presented byte must match the expected byte for its slot.
  always @(negedge clk) begin
    if (!rst && monitor_on && byte_valid) begin
      chk(int'(byte_index) == rx_count, "R4 byte_index order", byte_index, rx_count);
      if (rx_count < exp_n)
        chk(byte_data == exp_bytes[rx_count], "R2 aligned byte", byte_data, exp_bytes[rx_count]);
      else
        chk(1'b0, "R1 unexpected byte", byte_data, 0);
      rx_count++;
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic push_bit(input logic b);
    stim[nbits] = b;
    nbits++;
  endtask

  task automatic expect_from(input int start);
    exp_n    = (nbits - start) / 8;
    exp_drop = ((nbits - start) % 8) != 0;
    for (int k = 0; k < exp_n; k++)
      for (int b = 0; b < 8; b++)
        exp_bytes[k][7-b] = stim[start + 8*k + b];
  endtask

  task automatic build_frame(input vec_t v);
    logic [31:0] crc;
    logic [7:0]  pb;
    logic [7:0]  sfd;
    logic        fb;
    int          start;
    nbits = 0;
    crc   = '1;
    sfd   = 8'b10101011;
    for (int i = 0; i < int'(v.pre); i++) push_bit(logic'((int'(v.pre) - 1 - i) % 2));
    for (int b = 7; b >= 0; b--) push_bit(sfd[b]);
    start = nbits;
    for (int k = 0; k < int'(v.npay); k++) begin
      pb = v.seed + 8'(k) * v.step;
      for (int b = 7; b >= 0; b--) begin
        push_bit(pb[b]);
        fb  = crc[0] ^ pb[b];
        crc = crc >> 1;
        if (fb) crc = crc ^ 32'hEDB88320;
      end
    end
    crc = ~crc;
    for (int j = 0; j < 32; j++) push_bit(crc[j]);
    for (int t = 0; t < int'(v.tail); t++) push_bit(logic'(t % 2 == 0));
    if (v.flip) stim[start + 3] = ~stim[start + 3];
    expect_from(start);
  endtask

  task automatic run_and_judge(input bit gap, input bit exp_good, input string tag);
    rx_count   = 0;
    monitor_on = 1'b1;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      bit_valid = 1'b1;
      bit_in    = stim[i];
      if (gap && (i % 3 == 2)) begin
        @(negedge clk);
        bit_valid = 1'b0;
        bit_in    = ~stim[i];
      end
    end
    @(negedge clk);
    bit_valid = 1'b0;
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
    chk(done == 1'b0, {tag, " R10 done early"}, done, 0);
    @(negedge clk);
    chk(done == 1'b1, {tag, " R10 done timing"}, done, 1);
    chk(frame_good == exp_good, {tag, " R6 verdict"}, frame_good, exp_good);
    chk(int'(frame_len) == exp_n, {tag, " R5 frame_len"}, frame_len, exp_n);
    chk(bits_dropped == exp_drop, {tag, " R9 bits_dropped"}, bits_dropped, exp_drop);
    chk(rx_count == exp_n, {tag, " R1 byte count"}, rx_count, exp_n);
    @(negedge clk);
    chk(done == 1'b0, {tag, " R10 done one cycle"}, done, 0);
    monitor_on = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(byte_valid == 0 && done == 0, "R11 reset pulses", {byte_valid, done}, 0);
    chk(frame_good == 0 && frame_len == 0 && bits_dropped == 0, "R11 reset results",
        {frame_good, bits_dropped, frame_len}, 0);
    rst = 1'b0;

    // Table walk: offsets R1, R3 (0xAB payload), R5, R6, R8 (4-byte), R9 tails, R12 gaps
    for (int v = 0; v < NV; v++) begin
      build_frame(VECS[v]);
      run_and_judge(VECS[v].gap, VECS[v].good, $sformatf("vec%0d", v));
    end

    // R1 R2 R8 R9: delimiter straddling a byte boundary, short frame
    nbits = 0;
    begin
      logic [31:0] ex;
      ex = 32'b10101010_10101101_00100000_10110001;
      for (int b = 31; b >= 0; b--) push_bit(ex[b]);
    end
    exp_n = 2; exp_bytes[0] = 8'b01001000; exp_bytes[1] = 8'b00101100; exp_drop = 1'b1;
    run_and_judge(1'b0, 1'b0, "straddle R8");

    // R7: no delimiter
    nbits = 0;
    for (int i = 0; i < 40; i++) push_bit(logic'(i % 2 == 0));
    exp_n = 0; exp_drop = 1'b0;
    run_and_judge(1'b0, 1'b0, "nosfd R7");

    // R11: reset in mid-frame clears everything
    build_frame(VECS[0]);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      bit_valid = 1'b1;
      bit_in    = stim[i];
    end
    @(negedge clk);
    bit_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(byte_valid == 0 && done == 0, "R11 midframe pulses", {byte_valid, done}, 0);
    chk(frame_good == 0 && frame_len == 0, "R11 midframe results", {frame_good, frame_len}, 0);
    rst = 1'b0;
    build_frame(VECS[1]);
    run_and_judge(1'b0, 1'b1, "after_reset R11");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule